// File: doc/BRIEF.md
# Absolute-Indexed Address Sequencer with Page-Carry Fix-Up

This block steps an 8-bit processor through the bus cycles of absolute-indexed addressing. After the opcode fetch, the control logic pulses `start` with the operand address on `pc_in`, the index register value on `index` and the access class on `rmw_mode`. The sequencer then reads the base address low byte and high byte from `data_in`. It adds the index to the low byte and issues a first access with the unadjusted high byte. A one-bit carry memory then decides whether the high byte must be bumped by one for the following access.

The adder is shared between two cycles. In the high-byte fetch cycle it forms low byte plus index. In the speculative-access cycle it forms high byte plus the stored carry, so the corrected page is ready one cycle ahead of its use.

In read mode the correction cycle exists only when the carry is set. Without a carry, the speculative access is the final read. In read-modify-write mode the sequence has a fixed length: the corrected read always happens, followed by two write cycles.

The states are `ST_IDLE`, `ST_LO` (low-byte fetch), `ST_HI` (high-byte fetch plus index add), `ST_SPEC` (speculative access plus page increment), `ST_FIX` (access at the corrected address), `ST_WB_OLD` (write-back of the unmodified value) and `ST_WB_NEW` (write of the modified value). The transitions are:

- IDLE→LO on `start`.
- LO→HI and HI→SPEC unconditionally.
- SPEC→FIX when the stored carry is set or the mode is read-modify-write; otherwise SPEC→IDLE.
- FIX→WB_OLD in read-modify-write mode; otherwise FIX→IDLE.
- WB_OLD→WB_NEW unconditionally.
- WB_NEW→IDLE.

Top module: `idx_addr_seq`

## Requirements
- R1: After reset, `addr` is 0x0000 and both `wr` and `done` are 0.
- R2: In the first cycle after `start` is sampled, `addr` equals `pc_in`. In the second cycle it equals `pc_in`+1, modulo 2^16.
- R3: In the third cycle, `addr` holds the high byte (`data_in` of cycle 2) in bits 15:8. It holds (low byte + index) mod 256 in bits 7:0, where the low byte is `data_in` of cycle 1.
- R4: In read mode (`rmw_mode`=0) with no low-byte carry, `done` is 1 in the third cycle and the block is idle in the fourth.
- R5: In read mode with a low-byte carry, `done` is 0 in the third cycle. In the fourth cycle, `addr` is {high byte + 1, same low sum} and `done` is 1.
- R6: In read-modify-write mode (`rmw_mode`=1), the sequence lasts six cycles after `start` whether or not a carry occurs. The fourth cycle addresses {high byte + carry, low sum}, cycles five and six use that same address, and `done` is 1 only in cycle six.
- R7: `wr` is 1 only in cycles five and six of a read-modify-write sequence; every other access is a read (`wr`=0).
- R8: A carry with high byte 0xFF gives a corrected high byte of 0x00, with no other effect.
- R9: `start` is ignored while a sequence runs. After completion, `addr` in idle still shows the original operand address.
- R10: `index` and `rmw_mode` are sampled only with the accepted `start`; later changes do not affect the sequence.
- R11: `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence (accepted only in idle) |
| rmw_mode | input | 1 | 0 = read class, 1 = read-modify-write |
| pc_in | input | 16 | Address of the operand low byte |
| index | input | 8 | Index register value |
| data_in | input | 8 | Data bus read value |
| addr | output | 16 | Address bus |
| wr | output | 1 | 1 = write cycle, 0 = read cycle |
| done | output | 1 | Final data access of the sequence |

## Verification
The hardest situation to reach is a read-modify-write sequence in which the low-byte sum carries into a high byte of 0xFF. At the same time, a stray `start` and altered `index`/`rmw_mode` values arrive mid-sequence. The page must wrap to 0x00 on the corrected cycles while the timing stays at six cycles. The bench gets there by choosing operand bytes that force the carry from the data bus. On every sequence it flips the index and mode after capture and raises `start` with a different address during the speculative cycle. It then confirms from `addr` in idle that the original operand address survived.

// File: rtl/idxseq_pkg.sv
package idxseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_SPEC,
        ST_FIX,
        ST_WB_OLD,
        ST_WB_NEW
    } seq_state_e;
endpackage

// File: rtl/idxseq_add.sv
// Shared byte adder: low+index in one cycle, high+carry in the next.
module idxseq_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;
    assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    assign sum  = full[W-1:0];
    assign cout = full[W];
endmodule

// File: rtl/idxseq_fsm.sv
module idxseq_fsm
    import idxseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rmw,
    input  logic       carry,
    output seq_state_e state
);
    seq_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_LO;
            ST_LO:     nxt = ST_HI;
            ST_HI:     nxt = ST_SPEC;
            ST_SPEC:   nxt = (rmw || carry) ? ST_FIX : ST_IDLE;
            ST_FIX:    nxt = rmw ? ST_WB_OLD : ST_IDLE;
            ST_WB_OLD: nxt = ST_WB_NEW;
            ST_WB_NEW: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/idxseq_out.sv
module idxseq_out
    import idxseq_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  seq_state_e    state,
    input  logic [AW-1:0] pc_q,
    input  logic [DW-1:0] sum_lo_q,
    input  logic [DW-1:0] hi_q,
    input  logic [DW-1:0] hi_fix_q,
    input  logic          carry_q,
    input  logic          rmw_q,
    output logic [AW-1:0] addr,
    output logic          wr,
    output logic          done
);
    logic [DW-1:0] page;
    assign page = carry_q ? hi_fix_q : hi_q;

    always_comb begin
        addr = pc_q;
        wr   = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: addr = pc_q;
            ST_LO:   addr = pc_q;
            ST_HI:   addr = pc_q + AW'(1);
            ST_SPEC: begin
                addr = {hi_q, sum_lo_q};
                done = !rmw_q && !carry_q;
            end
            ST_FIX: begin
                addr = {page, sum_lo_q};
                done = !rmw_q;
            end
            ST_WB_OLD: begin
                addr = {page, sum_lo_q};
                wr   = 1'b1;
            end
            ST_WB_NEW: begin
                addr = {page, sum_lo_q};
                wr   = 1'b1;
                done = 1'b1;
            end
            default: addr = pc_q;
        endcase
    end
endmodule

// File: rtl/idx_addr_seq.sv
module idx_addr_seq
    import idxseq_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rmw_mode,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] index,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr,
    output logic          wr,
    output logic          done
);
    seq_state_e    state_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] idx_q, lo_q, hi_q, sum_lo_q, hi_fix_q;
    logic          rmw_q, carry_q;
    logic [DW-1:0] add_a, add_b, add_sum;
    logic          add_cin, add_cout;

    // Adder operand select: index add in ST_HI, page increment otherwise
    always_comb begin
        if (state_q == ST_HI) begin
            add_a   = lo_q;
            add_b   = idx_q;
            add_cin = 1'b0;
        end else begin
            add_a   = hi_q;
            add_b   = '0;
            add_cin = carry_q;
        end
    end

    idxseq_add #(.W(DW)) u_add (
        .a(add_a), .b(add_b), .cin(add_cin), .sum(add_sum), .cout(add_cout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= '0;
            idx_q    <= '0;
            rmw_q    <= 1'b0;
            lo_q     <= '0;
            hi_q     <= '0;
            sum_lo_q <= '0;
            hi_fix_q <= '0;
            carry_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    pc_q  <= pc_in;
                    idx_q <= index;
                    rmw_q <= rmw_mode;
                end
                ST_LO: lo_q <= data_in;
                ST_HI: begin
                    sum_lo_q <= add_sum;
                    carry_q  <= add_cout;
                    hi_q     <= data_in;
                end
                ST_SPEC: hi_fix_q <= add_sum;
                default: ;
            endcase
        end
    end

    idxseq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rmw(rmw_q), .carry(carry_q), .state(state_q)
    );

    idxseq_out #(.DW(DW)) u_out (
        .state(state_q), .pc_q(pc_q), .sum_lo_q(sum_lo_q), .hi_q(hi_q),
        .hi_fix_q(hi_fix_q), .carry_q(carry_q), .rmw_q(rmw_q),
        .addr(addr), .wr(wr), .done(done)
    );
endmodule

// File: rtl/idxseq_chk.sv
module idxseq_chk
    import idxseq_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input seq_state_e    state,
    input logic          rmw_q,
    input logic          carry_q,
    input logic [AW-1:0] addr,
    input logic          wr,
    input logic          done
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_WRITE_RMW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> rmw_q); // R7
    AST_WRITE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !done) |=> (wr && done)); // R7
    AST_READ_SKIP_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPEC && !rmw_q && !carry_q) |-> done); // R4
    AST_RMW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPEC && rmw_q) |=> (state == ST_FIX)); // R6
    AST_FIX_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX) |-> addr[DW-1:0] == $past(addr[DW-1:0])); // R5
    AST_FIX_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX) |->
            addr[AW-1:DW] == DW'($past(addr[AW-1:DW]) + {{(DW-1){1'b0}}, carry_q})); // R8
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_LO)); // R9
endmodule

bind idx_addr_seq idxseq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .rmw_q(rmw_q),
    .carry_q(carry_q), .addr(addr), .wr(wr), .done(done)
);

// File: tb/idx_addr_seq_tb.sv
`timescale 1ns/1ps
module idx_addr_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rmw_mode = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  index = '0;
    logic [7:0]  data_in = '0;
    logic [15:0] addr;
    logic        wr, done;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    idx_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rmw_mode(rmw_mode),
        .pc_in(pc_in), .index(index), .data_in(data_in),
        .addr(addr), .wr(wr), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full sequence with mid-run disturbances (R9, R10)
    task automatic run_op(input logic [15:0] pc, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] idx, input logic rmw);
        logic [8:0] full = {1'b0, lo} + {1'b0, idx};
        logic       cy   = full[8];
        logic [7:0] sum  = full[7:0];
        logic [7:0] page = cy ? 8'(hi + 8'd1) : hi;
        @(negedge clk);
        start = 1'b1; pc_in = pc; index = idx; rmw_mode = rmw;
        @(negedge clk);
        start = 1'b0;
        chk("R2 lo fetch addr", 32'(addr), 32'(pc));
        chk("R7 lo fetch read", 32'(wr), 0);
        data_in = lo;
        @(negedge clk);
        chk("R2 hi fetch addr", 32'(addr), 32'(16'(pc + 16'd1)));
        data_in = hi;
        index = ~idx; rmw_mode = ~rmw;               // R10 late changes
        @(negedge clk);
        chk("R3 speculative addr", 32'(addr), 32'({hi, sum}));
        chk("R4 spec done", 32'(done), 32'(!rmw && !cy));
        chk("R7 spec read", 32'(wr), 0);
        start = 1'b1; pc_in = pc ^ 16'h5A5A;         // R9 stray start
        if (rmw || cy) begin
            @(negedge clk);
            start = 1'b0;
            chk("R5 fix addr", 32'(addr), 32'({page, sum}));
            chk("R5 fix done", 32'(done), 32'(!rmw));
            chk("R7 fix read", 32'(wr), 0);
            if (rmw) begin
                @(negedge clk);
                chk("R6 wb_old addr", 32'(addr), 32'({page, sum}));
                chk("R7 wb_old write", 32'(wr), 1);
                chk("R6 wb_old no done", 32'(done), 0);
                @(negedge clk);
                chk("R6 wb_new addr", 32'(addr), 32'({page, sum}));
                chk("R7 wb_new write", 32'(wr), 1);
                chk("R6 wb_new done", 32'(done), 1);
            end
        end
        @(negedge clk);
        start = 1'b0;
        chk("R11 done dropped", 32'(done), 0);
        chk("R7 idle read", 32'(wr), 0);
        chk("R9 start ignored addr", 32'(addr), 32'(pc));
        @(negedge clk);
        chk("R9 stays idle", 32'(done), 0);
        index = '0; rmw_mode = 1'b0;
    endtask

    task automatic test_reset;
        chk("R1 addr", 32'(addr), 0);
        chk("R1 wr", 32'(wr), 0);
        chk("R1 done", 32'(done), 0);
    endtask

    task automatic test_read_no_cross;  run_op(16'h1230, 8'h10, 8'h44, 8'h05, 1'b0); endtask
    task automatic test_read_cross;     run_op(16'h2000, 8'hF0, 8'h44, 8'h20, 1'b0); endtask
    task automatic test_rmw_no_cross;   run_op(16'h3456, 8'h7F, 8'h12, 8'h00, 1'b1); endtask
    task automatic test_rmw_cross;      run_op(16'h0400, 8'h80, 8'h12, 8'h80, 1'b1); endtask
    task automatic test_wrap_read_R8;   run_op(16'h0800, 8'hFF, 8'hFF, 8'h01, 1'b0); endtask
    task automatic test_wrap_rmw_R8;    run_op(16'h0900, 8'hC0, 8'hFF, 8'hFF, 1'b1); endtask
    task automatic test_pc_wrap_R2;     run_op(16'hFFFF, 8'h00, 8'h00, 8'hFF, 1'b0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1;
        test_reset;
        #10 rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_read_no_cross;
        test_read_cross;
        test_rmw_no_cross;
        test_rmw_cross;
        test_wrap_read_R8;
        test_wrap_rmw_R8;
        test_pc_wrap_R2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule